// File: doc/BRIEF.md
# Register-Mapped SPI Master with Word Queues

The block is a serial peripheral interface controller that only acts as master. Software reaches it through a small 32-bit register bus. Words written to the transmit data address join a transmit queue. A bit engine takes them one at a time, moves each onto MOSI with a generated SCK, and captures the same number of bits from MISO. Each finished word goes into a receive queue, which software empties by reading the receive data address. Every shifted word yields exactly one received word.

Some settings are fixed when the block is built:

- the word width (8, 16 or 32 bits);
- the SCK half-period, in clock cycles;
- the queue depth;
- the number of select lines.

Software controls the clock polarity and phase, the bit order and an internal loopback path. A transmit-hold bit lets software fill the queue before any bit moves. The active-low select lines work in one of two ways: they follow a select register at all times, or they assert only while a word is being shifted.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control register reads 0x100 (only the hold bit set), status reads 0x005, the select register reads all ones, SCK is low and every ss_n line is high. Reset is asynchronous and is released two clock edges after rst_n rises.
- R2: The register addresses are 0x60 control, 0x64 status, 0x68 transmit data (write pushes), 0x6C receive data (read pops) and 0x70 select.
  - Control bits read back at these positions: loopback 0, enable 1, master 2, CPOL 3, CPHA 4, manual select 7, hold 8, LSB-first 9.
  - Status bits are: receive empty 0, receive full 1, transmit empty 2, transmit full 3, mode fault 4. Mode fault always reads 0.
  - Any other address reads 0.
- R3: A word starts shifting only when enable=1, master=1, hold=0 and the transmit queue is not empty. Otherwise queued words stay queued, and there is no SCK or select activity.
- R4: Every shifted word pushes exactly one word into the receive queue. MOSI carries the transmitted word and the received word is the MISO word.
- R5: SCK idles at CPOL. With CPHA=0, each bit is presented before the first edge and sampled on leading edges. With CPHA=1, each bit is presented on leading edges and sampled on trailing edges.
- R6: Bits go MSB first by default. Control bit 9 makes both directions LSB first.
- R7: With loopback (control bit 0) the receive side samples MOSI in place of MISO, so the received word equals the sent word in every mode.
- R8: With manual select clear, ss_n is all ones while idle and equals the select register while a word shifts.
- R9: With manual select set, ss_n equals the select register from the cycle after the write, whether or not anything is shifting.
- R10: Writing 1 to control bit 5 empties the transmit queue and writing 1 to bit 6 empties the receive queue. Both bits read back 0, and words flushed from the transmit queue are never sent.
- R11: A write to a full transmit queue is ignored. The queue keeps its DEPTH words, status shows transmit full, and the extra word is never sent.
- R12: A read of an empty receive queue returns 0 and changes no status bit.
- R13: SCK changes every SCK_DIV clock cycles. In automatic select mode ss_n stays low for exactly 2*DATA_W*SCK_DIV cycles per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at 0x6C) |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
The bench runs word streams through all four clock modes, in MSB-first and LSB-first order, with a slave model that returns a different pattern on MISO. This tells apart sampling on the wrong edge, swapped bit order and a received word that merely echoes MOSI. Loopback runs show the receive side taking MOSI instead of MISO. Stimuli such as preloading with hold set, a missing enable, a queue overfilled by one word, flushes and an empty-queue read each show whether a word was sent that should not have been, or one was dropped that should have been kept. The select-low time per word is measured against the configured SCK rate.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam logic [6:0] ADDR_CTRL = 7'h60;
  localparam logic [6:0] ADDR_STAT = 7'h64;
  localparam logic [6:0] ADDR_TXD  = 7'h68;
  localparam logic [6:0] ADDR_RXD  = 7'h6C;
  localparam logic [6:0] ADDR_SEL  = 7'h70;

  localparam int C_LOOP   = 0;
  localparam int C_EN     = 1;
  localparam int C_MASTER = 2;
  localparam int C_CPOL   = 3;
  localparam int C_CPHA   = 4;
  localparam int C_TXCLR  = 5;
  localparam int C_RXCLR  = 6;
  localparam int C_MANSEL = 7;
  localparam int C_HOLD   = 8;
  localparam int C_LSB    = 9;

  localparam int CTRL_W = 10;
  // bits that hold state; the two flush bits are strobes only
  localparam logic [CTRL_W-1:0] CTRL_KEEP  = 10'h39F;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 10'h100;

  typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;
endpackage

// File: rtl/spi_fifo_sync.sv
module spi_fifo_sync #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_q] <= din;
  end
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SCK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              loopback,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              miso,
  output logic              mosi,
  output logic              sck_toggled,
  output logic              busy,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  sh_state_e         state_q, state_d;
  logic [EW-1:0]     edge_q, edge_d;
  logic [DATA_W-1:0] tsh_q, tsh_d, rsh_q, rsh_d;
  logic              tog_q, tog_d;
  logic              tick, start, lead, last, first, samp, drv, sin;

  generate
    if (SCK_DIV > 1) begin : g_div
      localparam int DW = $clog2(SCK_DIV);
      localparam logic [DW-1:0] DIV_END = DW'(SCK_DIV - 1);
      logic [DW-1:0] div_q, div_d;
      assign tick = (state_q == SH_RUN) && (div_q == DIV_END);
      always_comb begin
        if (state_q != SH_RUN || tick) div_d = '0;
        else                           div_d = div_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end
    end else begin : g_nodiv
      assign tick = (state_q == SH_RUN);
    end
  endgenerate

  assign start = (state_q == SH_IDLE) && go && tx_valid;
  assign tx_pop = start;
  assign lead  = ~edge_q[0];
  assign last  = (edge_q == LAST_EDGE);
  assign first = (edge_q == '0);
  assign samp  = tick && (cpha ? !lead : lead);
  assign drv   = tick && (cpha ? (lead && !first) : (!lead && !last));
  assign mosi  = lsb_first ? tsh_q[0] : tsh_q[DATA_W-1];
  assign sin   = loopback ? mosi : miso;

  always_comb begin
    state_d = state_q;
    edge_d  = edge_q;
    tog_d   = tog_q;
    tsh_d   = tsh_q;
    rsh_d   = rsh_q;
    if (start) begin
      state_d = SH_RUN;
      edge_d  = '0;
      tog_d   = 1'b0;
      tsh_d   = tx_data;
    end else if (tick) begin
      edge_d = edge_q + 1'b1;
      tog_d  = ~tog_q;
      if (last) state_d = SH_IDLE;
    end
    if (drv) begin
      if (lsb_first) tsh_d = {1'b0, tsh_q[DATA_W-1:1]};
      else           tsh_d = {tsh_q[DATA_W-2:0], 1'b0};
    end
    if (samp) begin
      if (lsb_first) rsh_d = {sin, rsh_q[DATA_W-1:1]};
      else           rsh_d = {rsh_q[DATA_W-2:0], sin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      edge_q  <= '0;
      tog_q   <= 1'b0;
      tsh_q   <= '0;
      rsh_q   <= '0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      tog_q   <= tog_d;
      tsh_q   <= tsh_d;
      rsh_q   <= rsh_d;
    end
  end

  assign sck_toggled = tog_q;
  assign busy        = (state_q == SH_RUN);
  assign rx_push     = tick && last;
  assign rx_data     = rsh_d;
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 16,
  parameter int SCK_DIV = 2,
  parameter int NUM_SS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [6:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n
);
  generate
    if (DATA_W != 8 && DATA_W != 16 && DATA_W != 32) begin : g_bad_width
      $error("DATA_W must be 8, 16 or 32");
    end
  endgenerate

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NUM_SS-1:0] sel_q, sel_d;
  logic              wr_ctrl, wr_sel, tx_push, rx_pop, tx_flush, rx_flush;
  logic              tx_empty, tx_full, rx_empty, rx_full, tx_pop;
  logic [DATA_W-1:0] tx_dout, rx_dout, rx_data;
  logic              rx_push, shf_busy, shf_go, sck_tog;
  logic              cpol_bit, manual_bit;
  logic [4:0]        stat_vec;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_sel   = bus_wr && (bus_addr == ADDR_SEL);
  assign tx_push  = bus_wr && (bus_addr == ADDR_TXD);
  assign rx_pop   = bus_rd && (bus_addr == ADDR_RXD);
  assign tx_flush = wr_ctrl && bus_wdata[C_TXCLR];
  assign rx_flush = wr_ctrl && bus_wdata[C_RXCLR];

  always_comb begin
    ctrl_d = ctrl_q;
    sel_d  = sel_q;
    if (wr_ctrl) ctrl_d = bus_wdata[CTRL_W-1:0] & CTRL_KEEP;
    if (wr_sel)  sel_d  = bus_wdata[NUM_SS-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= CTRL_RESET;
      sel_q  <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      sel_q  <= sel_d;
    end
  end

  spi_fifo_sync #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_sync_n), .flush(tx_flush),
    .push(tx_push), .din(bus_wdata[DATA_W-1:0]),
    .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full)
  );

  spi_fifo_sync #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_sync_n), .flush(rx_flush),
    .push(rx_push), .din(rx_data),
    .pop(rx_pop), .dout(rx_dout), .empty(rx_empty), .full(rx_full)
  );

  assign shf_go = ctrl_q[C_EN] && ctrl_q[C_MASTER] && !ctrl_q[C_HOLD];

  spi_bit_engine #(.DATA_W(DATA_W), .SCK_DIV(SCK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_sync_n), .go(shf_go),
    .cpha(ctrl_q[C_CPHA]), .lsb_first(ctrl_q[C_LSB]), .loopback(ctrl_q[C_LOOP]),
    .tx_valid(!tx_empty), .tx_data(tx_dout), .tx_pop(tx_pop),
    .miso(miso), .mosi(mosi), .sck_toggled(sck_tog), .busy(shf_busy),
    .rx_push(rx_push), .rx_data(rx_data)
  );

  assign cpol_bit   = ctrl_q[C_CPOL];
  assign manual_bit = ctrl_q[C_MANSEL];
  assign sck        = cpol_bit ^ sck_tog;
  assign ss_n       = (manual_bit || shf_busy) ? sel_q : '1;
  assign stat_vec   = {1'b0, tx_full, tx_empty, rx_full, rx_empty};

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = 32'(ctrl_q);
      ADDR_STAT: bus_rdata = 32'(stat_vec);
      ADDR_RXD:  bus_rdata = rx_empty ? '0 : 32'(rx_dout);
      ADDR_SEL:  bus_rdata = 32'(sel_q);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int NUM_SS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              go,
  input logic              sck,
  input logic              cpol,
  input logic              manual,
  input logic [NUM_SS-1:0] ss_n,
  input logic [4:0]        stat
);
  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));

  // R8
  auto_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual && !busy) |-> (ss_n == '1));

  // R3
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));

  // R2
  queue_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[0] && stat[1]) && !(stat[2] && stat[3]) && !stat[4]);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.NUM_SS(NUM_SS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .busy(shf_busy), .go(shf_go),
  .sck(sck), .cpol(cpol_bit), .manual(manual_bit), .ss_n(ss_n),
  .stat(stat_vec)
);

// File: tb/sim_spi_fifo_master.sv
`timescale 1ns/1ps
module sim_spi_fifo_master;
  localparam int DW = 8, DEPTH = 16, DIV = 2, NSS = 4;
  localparam logic [6:0] A_CTRL = 7'h60, A_STAT = 7'h64, A_TXD = 7'h68,
                         A_RXD = 7'h6C, A_SEL = 7'h70;
  localparam logic [9:0] LOOP = 10'h001, EN = 10'h002, MST = 10'h004,
                         CPOL = 10'h008, CPHA = 10'h010, TXCLR = 10'h020,
                         RXCLR = 10'h040, MAN = 10'h080, HOLD = 10'h100,
                         LSB = 10'h200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, miso = 1'b0;
  logic [NSS-1:0] ss_n;

  spi_fifo_master #(.DATA_W(DW), .DEPTH(DEPTH), .SCK_DIV(DIV), .NUM_SS(NSS)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [DW-1:0] exp_mosi[$], exp_rx[$], slave_q[$];
  logic cpol_m = 0, cpha_m = 0, lsb_m = 0, loop_m = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  // driver: queues a word and the items it must produce
  task automatic send(input logic [DW-1:0] w);
    wr(A_TXD, 32'(w));
    exp_mosi.push_back(w);
    slave_q.push_back(w ^ 8'h5A);
    exp_rx.push_back(loop_m ? w : (w ^ 8'h5A));
  endtask

  task automatic set_mode(input logic [9:0] m);
    cpol_m = m[3]; cpha_m = m[4]; lsb_m = m[9]; loop_m = m[0];
  endtask

  task automatic drain(input string req, input int n);
    logic [31:0] d;
    logic [DW-1:0] e;
    for (int i = 0; i < n; i++) begin
      rd(A_RXD, d);
      e = (exp_rx.size() > 0) ? exp_rx.pop_front() : '0;
      chk(req, d, 32'(e));
    end
    rd(A_STAT, d);
    chk({req, " one rx word per word"}, 32'(d[0]), 32'd1);
  endtask

  // slave model: checks MOSI words, returns its own pattern on MISO
  logic [DW-1:0] mw, cap;
  int kin = 0, kout = 0;
  bit active = 1'b0;
  function automatic int bpos(input int k);
    return lsb_m ? k : (DW - 1 - k);
  endfunction

  always @(negedge ss_n[0]) begin
    kin = 0; kout = 0; active = 1'b1; cap = '0;
    mw = (slave_q.size() > 0) ? slave_q.pop_front() : '0;
    if (!cpha_m) miso = mw[bpos(0)];
  end

  always @(sck) begin
    if (active) begin
      automatic bit leading = (sck != cpol_m);
      if (cpha_m ? !leading : leading) begin
        cap[bpos(kin)] = mosi;
        kin++;
        if (kin == DW) begin
          active = 1'b0;
          if (exp_mosi.size() == 0) chk("R4 R11 unexpected MOSI word", 32'(cap), 32'hFFFF_FFFF);
          else chk("R4 R5 R6 MOSI word", 32'(cap), 32'(exp_mosi.pop_front()));
        end
      end
      if (cpha_m ? leading : !leading) begin
        if (cpha_m) begin
          miso = mw[bpos(kout)]; kout++;
        end else begin
          kout++;
          if (kout < DW) miso = mw[bpos(kout)];
        end
      end
    end
  end

  // select-low time per word
  realtime t_fall = 0.0;
  bit time_en = 1'b0;
  always @(negedge ss_n[0]) t_fall = $realtime;
  always @(posedge ss_n[0]) if (time_en)
    chk("R13 select low time (ns)", 32'(int'($realtime - t_fall)), 32'(2 * DW * DIV * 5));

  task automatic run_xfer(input string tag, input logic [9:0] mode,
                          input logic [47:0] words, input int n);
    logic [31:0] d;
    set_mode(mode);
    wr(A_SEL, 32'hE);
    wr(A_CTRL, 32'(EN | MST | HOLD | mode));
    @(negedge clk);
    chk({tag, " R5 idle sck = CPOL"}, 32'(sck), 32'(cpol_m));
    for (int i = 0; i < n; i++) send(words[8*i +: 8]);
    cycles(20);
    @(negedge clk);
    chk({tag, " R3 hold keeps selects off"}, 32'(ss_n), 32'hF);
    rd(A_STAT, d);
    chk({tag, " R3 hold keeps words queued"}, 32'(d[2]), 32'd0);
    time_en = 1'b1;
    wr(A_CTRL, 32'(EN | MST | mode));
    for (int i = 0; i < 10 && ss_n == 4'hF; i++) @(negedge clk);
    chk({tag, " R8 select during word"}, 32'(ss_n), 32'hE);
    cycles(n * 34 + 10);
    time_en = 1'b0;
    @(negedge clk);
    chk({tag, " R5 sck back at CPOL"}, 32'(sck), 32'(cpol_m));
    chk({tag, " R8 select released"}, 32'(ss_n), 32'hF);
    drain({tag, " R4 rx word"}, n);
    wr(A_CTRL, 32'(EN | MST | HOLD));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    logic [31:0] d;
    cycles(3);
    @(negedge clk); rst_n = 1'b1;
    cycles(4);

    // R1 reset state
    rd(A_CTRL, d); chk("R1 control after reset", d, 32'h100);
    rd(A_STAT, d); chk("R1 status after reset", d, 32'h005);
    rd(A_SEL, d);  chk("R1 select after reset", d, 32'hF);
    chk("R1 sck after reset", 32'(sck), 32'd0);
    chk("R1 ss_n after reset", 32'(ss_n), 32'hF);

    // R2 register map
    wr(A_CTRL, 32'hFFFF_FF9F);
    rd(A_CTRL, d); chk("R2 control readback", d, 32'h39F);
    wr(A_CTRL, 32'(HOLD));
    wr(A_SEL, 32'hB);
    rd(A_SEL, d);  chk("R2 select readback", d, 32'hB);
    rd(7'h00, d);  chk("R2 unmapped read", d, 32'h0);
    @(negedge clk);
    chk("R8 idle automatic select", 32'(ss_n), 32'hF);

    // R9 manual select
    wr(A_CTRL, 32'(MAN | HOLD));
    @(negedge clk);
    chk("R9 manual select follows register", 32'(ss_n), 32'hB);
    wr(A_SEL, 32'h7);
    @(negedge clk);
    chk("R9 manual select tracks new value", 32'(ss_n), 32'h7);
    wr(A_CTRL, 32'(HOLD));
    @(negedge clk);
    chk("R8 automatic select off when idle", 32'(ss_n), 32'hF);

    // main function across modes, orders and loopback
    run_xfer("mode0 msb", 10'h000, 48'h01_FF_00_81_3C_A5, 6);
    run_xfer("mode1 msb", CPHA, 48'h0000_C3_96_5A_E1, 4);
    run_xfer("mode2 msb", CPOL, 48'h0000_7E_0F_F0_B4, 4);
    run_xfer("mode3 msb", CPOL | CPHA, 48'h0000_11_22_C8_6D, 4);
    run_xfer("R6 mode0 lsb", LSB, 48'h0000_80_01_E0_35, 4);
    run_xfer("R6 mode3 lsb", LSB | CPOL | CPHA, 48'h0000_06_9C_2B_D2, 4);
    run_xfer("R7 loop mode1 lsb", LOOP | CPHA | LSB, 48'h0000_C0_03_A6_59, 4);
    run_xfer("R7 loop mode2 msb", LOOP | CPOL, 48'h0000_F1_1E_88_44, 4);

    // R11 overfill of transmit queue
    set_mode(10'h000);
    wr(A_SEL, 32'hE);
    wr(A_CTRL, 32'(EN | MST | HOLD));
    for (int i = 0; i < DEPTH; i++) send(8'(i * 13 + 7));
    wr(A_TXD, 32'hEE);
    rd(A_STAT, d);
    chk("R11 transmit full flag", 32'(d[3:2]), 32'h2);
    wr(A_CTRL, 32'(EN | MST));
    cycles(DEPTH * 34 + 10);
    rd(A_STAT, d);
    chk("R11 receive full after DEPTH words", 32'(d[2:0]), 32'h6);
    drain("R11 rx word", DEPTH);
    chk("R11 all DEPTH words sent", 32'(exp_mosi.size()), 32'd0);

    // R10 transmit flush
    wr(A_CTRL, 32'(EN | MST | HOLD));
    wr(A_TXD, 32'h11); wr(A_TXD, 32'h22); wr(A_TXD, 32'h33);
    rd(A_STAT, d); chk("R10 words queued before flush", 32'(d[2]), 32'd0);
    wr(A_CTRL, 32'(EN | MST | HOLD | TXCLR));
    rd(A_STAT, d); chk("R10 transmit flush empties", 32'(d[2]), 32'd1);
    rd(A_CTRL, d); chk("R10 flush bit reads zero", d, 32'(EN | MST | HOLD));
    wr(A_CTRL, 32'(EN | MST));
    cycles(40);
    @(negedge clk);
    chk("R10 flushed words not sent", 32'(ss_n), 32'hF);

    // R10 receive flush
    set_mode(LOOP);
    wr(A_CTRL, 32'(EN | MST | HOLD | LOOP));
    send(8'h9A); send(8'h4B);
    exp_rx.delete();
    wr(A_CTRL, 32'(EN | MST | LOOP));
    cycles(80);
    rd(A_STAT, d); chk("R10 receive holds words", 32'(d[0]), 32'd0);
    wr(A_CTRL, 32'(EN | MST | HOLD | RXCLR));
    rd(A_STAT, d); chk("R10 receive flush empties", 32'(d[0]), 32'd1);
    rd(A_CTRL, d); chk("R10 receive flush bit reads zero", d, 32'(EN | MST | HOLD));

    // R12 read from empty receive queue
    rd(A_RXD, d);  chk("R12 empty read value", d, 32'h0);
    rd(A_STAT, d); chk("R12 status unchanged", d, 32'h005);

    // R3 enable missing
    set_mode(10'h000);
    wr(A_CTRL, 32'(MST));
    wr(A_TXD, 32'h5C);
    cycles(40);
    @(negedge clk);
    chk("R3 no shifting without enable", 32'(ss_n), 32'hF);
    rd(A_STAT, d); chk("R3 word stays queued", 32'(d[2]), 32'd0);
    wr(A_CTRL, 32'(MST | HOLD | TXCLR));

    cycles(5);
    chk("R4 no MOSI words outstanding", 32'(exp_mosi.size()), 32'd0);
    report();
  end
endmodule